// File: doc/BRIEF.md
# Atomic Test-and-Set Lock Unit

This block holds a bank of single-bit lock words and serves several requesters that contend for them. A requester raises its valid line with a lock number and an operation: test-and-set, release or read. It holds the request until its grant line rises. A round-robin arbiter admits at most one request per cycle. The admitted request's read of the word and its write back happen in that same clock edge, so no other access can fall between the test and the set.

One cycle after admission the unit returns the requester number, the value the word held before the operation, and a success flag. A test-and-set that finds the word free takes the lock and reports success. One that finds the word held reports failure, leaves the word alone, and the requester may try again later. Release always clears the word. Spinning, backoff and the software around the lock belong to the requesters.

Top module: `tas_lock_unit`

## Requirements
- R1: After reset every lock word reads 0 (free), no response is valid, and the round-robin pointer favours requester 0.
- R2: In any cycle at most one grant bit is high, only for a requester whose valid is high, and a grant is issued whenever any valid is high.
- R3: Round-robin order: the search for a grant starts at the requester numbered one above the last granted one, wrapping past the highest to 0.
- R4: Test-and-set (op code 01) on a word holding 0 sets it to 1 and responds with ok=1 and old=0.
- R5: Test-and-set on a word holding 1 responds with ok=0 and old=1, and the word stays 1.
- R6: Release (op code 10) writes 0 and responds with ok=1 and old equal to the prior value. A release of a free lock is accepted and leaves the word at 0.
- R7: Read (op codes 00 and 11) responds with ok=1 and old equal to the word, and does not change it.
- R8: Each granted request produces exactly one response, on the cycle after the grant, carrying the granted requester's number. No response appears in a cycle that follows a cycle without a grant.
- R9: When several requesters present test-and-set to the same free lock together, exactly one of them succeeds. That is the round-robin winner, and every other one fails.
- R10: Mutual exclusion: two successful test-and-set responses on one lock always have a release of that lock between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Per-requester request pending |
| req_op | input | 2*NUM_REQ | Per-requester operation, 2 bits each (00 read, 01 test-and-set, 10 release, 11 read) |
| req_idx | input | IDX_W*NUM_REQ | Per-requester lock number, must be below NUM_LOCKS |
| req_gnt | output | NUM_REQ | One-hot grant; the request is admitted in this cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | ID_W | Requester the response belongs to |
| rsp_ok | output | 1 | Success flag |
| rsp_old | output | 1 | Lock value before the operation |

## Verification
The two functions that collide are the arbitration among requesters and the test-and-set on one word. Both come into play when several requesters target the same free lock in the same cycle. The bench provokes this directly by raising test-and-set on one lock from every requester at once. Random traffic confined to a few lock numbers then makes such overlaps common. The outcome is judged two ways. A bench model predicts the grant order and the response of each admitted request. A separate tracker, fed only by the observed responses, flags any second success on a lock that has had no release in between.

// File: rtl/tas_lock_pkg.sv
package tas_lock_pkg;
    typedef enum logic [1:0] {
        OP_READ = 2'b00,
        OP_TAS  = 2'b01,
        OP_REL  = 2'b10,
        OP_PEEK = 2'b11
    } lock_op_e;
endpackage

// File: rtl/tas_rr_arbiter.sv
module tas_rr_arbiter #(
    parameter int NUM_REQ = 4,
    localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] valid,
    output logic [NUM_REQ-1:0] gnt,
    output logic               any_gnt,
    output logic [ID_W-1:0]    win_id
);
    typedef struct packed {
        logic [ID_W-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        gnt     = '0;
        any_gnt = 1'b0;
        win_id  = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
            int c;
            c = int'(st_q.ptr) + k;
            if (c >= NUM_REQ) c = c - NUM_REQ;
            if (!any_gnt && valid[c]) begin
                gnt[c]  = 1'b1;
                any_gnt = 1'b1;
                win_id  = ID_W'(c);
            end
        end
        if (any_gnt) begin
            st_d.ptr = (int'(win_id) == NUM_REQ - 1) ? '0 : ID_W'(int'(win_id) + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R2
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~valid) == '0);
    // R2
    work_conserving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid != '0) |-> (gnt != '0));
endmodule

// File: rtl/tas_lock_store.sv
module tas_lock_store
    import tas_lock_pkg::*;
#(
    parameter int NUM_LOCKS = 8,
    parameter int NUM_REQ   = 4,
    localparam int IDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
    localparam int ID_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [ID_W-1:0]  acc_id,
    input  lock_op_e         acc_op,
    input  logic [IDX_W-1:0] acc_idx,
    output logic             rsp_valid,
    output logic [ID_W-1:0]  rsp_id,
    output logic             rsp_ok,
    output logic             rsp_old
);
    typedef struct packed {
        logic [NUM_LOCKS-1:0] words;
        logic                 vld;
        logic [ID_W-1:0]      id;
        logic                 ok;
        logic                 old;
        lock_op_e             op;
        logic [IDX_W-1:0]     idx;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        logic cur;
        st_d     = st_q;
        st_d.vld = acc;
        cur      = st_q.words[acc_idx];
        if (acc) begin
            st_d.id  = acc_id;
            st_d.op  = acc_op;
            st_d.idx = acc_idx;
            st_d.old = cur;
            unique case (acc_op)
                OP_TAS: begin
                    st_d.ok             = ~cur;
                    st_d.words[acc_idx] = 1'b1;
                end
                OP_REL: begin
                    st_d.ok             = 1'b1;
                    st_d.words[acc_idx] = 1'b0;
                end
                default: st_d.ok = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_id    = st_q.id;
    assign rsp_ok    = st_q.ok;
    assign rsp_old   = st_q.old;

    // R8
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);
    // R8
    no_rsp_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);
    // R4
    tas_leaves_word_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.op == OP_TAS) |-> st_q.words[st_q.idx]);
    // R6
    rel_leaves_word_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.op == OP_REL) |-> !st_q.words[st_q.idx]);
    // R10
    tas_win_only_on_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && acc_op == OP_TAS && st_q.words[acc_idx]) |=> !rsp_ok);
endmodule

// File: rtl/tas_lock_unit.sv
module tas_lock_unit
    import tas_lock_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int NUM_LOCKS = 8,
    localparam int IDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
    localparam int ID_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       req_valid,
    input  logic [2*NUM_REQ-1:0]     req_op,
    input  logic [IDX_W*NUM_REQ-1:0] req_idx,
    output logic [NUM_REQ-1:0]       req_gnt,
    output logic                     rsp_valid,
    output logic [ID_W-1:0]          rsp_id,
    output logic                     rsp_ok,
    output logic                     rsp_old
);
    logic             any_gnt;
    logic [ID_W-1:0]  win_id;
    lock_op_e         sel_op;
    logic [IDX_W-1:0] sel_idx;

    tas_rr_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (req_valid),
        .gnt     (req_gnt),
        .any_gnt (any_gnt),
        .win_id  (win_id)
    );

    always_comb begin
        sel_op  = lock_op_e'(req_op[2*win_id +: 2]);
        sel_idx = req_idx[IDX_W*win_id +: IDX_W];
    end

    tas_lock_store #(.NUM_LOCKS(NUM_LOCKS), .NUM_REQ(NUM_REQ)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (any_gnt),
        .acc_id    (win_id),
        .acc_op    (sel_op),
        .acc_idx   (sel_idx),
        .rsp_valid (rsp_valid),
        .rsp_id    (rsp_id),
        .rsp_ok    (rsp_ok),
        .rsp_old   (rsp_old)
    );
endmodule

// File: tb/tas_lock_unit_tb.sv
module tas_lock_unit_tb;
    localparam int NR = 4;
    localparam int NL = 8;
    localparam int IW = 3;
    localparam int RW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0]    req_valid = '0;
    logic [2*NR-1:0]  req_op = '0;
    logic [IW*NR-1:0] req_idx = '0;
    logic [NR-1:0]    req_gnt;
    logic             rsp_valid;
    logic [RW-1:0]    rsp_id;
    logic             rsp_ok;
    logic             rsp_old;

    always #4 clk = ~clk;

    tas_lock_unit #(.NUM_REQ(NR), .NUM_LOCKS(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_gnt(req_gnt), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .rsp_ok(rsp_ok), .rsp_old(rsp_old)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    logic       m_lock [NL];
    int         m_ptr;
    logic       pv   [NR];
    logic [1:0] pop  [NR];
    int         pidx [NR];
    logic       e_vld, e_ok, e_old;
    int         e_id, e_idx;
    logic [1:0] e_op;
    logic       obs_held [NL];
    int         tas_wins;

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pick(input logic [NR-1:0] v, input int p);
        for (int k = 0; k < NR; k++) begin
            int c = (p + k) % NR;
            if (v[c]) return c;
        end
        return -1;
    endfunction

    task automatic step();
        logic [NR-1:0] v;
        int w;
        @(negedge clk);
        // response of the request admitted in the previous cycle (R8)
        chk(rsp_valid == e_vld, "R8 rsp_valid", int'(rsp_valid), int'(e_vld));
        if (e_vld && rsp_valid) begin
            chk(int'(rsp_id) == e_id, "R8 rsp_id", int'(rsp_id), e_id);
            chk(rsp_old == e_old, (e_op == 2'b01) ? "R4/R5 old" :
                (e_op == 2'b10) ? "R6 old" : "R7 old", int'(rsp_old), int'(e_old));
            chk(rsp_ok == e_ok, (e_op == 2'b01) ? "R4/R5 ok" :
                (e_op == 2'b10) ? "R6 ok" : "R7 ok", int'(rsp_ok), int'(e_ok));
            if (e_op == 2'b01 && rsp_ok) begin
                chk(!obs_held[e_idx], "R10 second holder", 1, 0);
                obs_held[e_idx] = 1'b1;
                tas_wins++;
            end else if (e_op == 2'b10) begin
                obs_held[e_idx] = 1'b0;
            end
        end
        for (int r = 0; r < NR; r++) begin
            req_valid[r]          = pv[r];
            req_op[2*r +: 2]      = pop[r];
            req_idx[IW*r +: IW]   = IW'(pidx[r]);
        end
        #1;
        for (int r = 0; r < NR; r++) v[r] = pv[r];
        w = pick(v, m_ptr);
        if (w < 0) begin
            chk(req_gnt == '0, "R2 idle grant", int'(req_gnt), 0);
            e_vld = 1'b0;
        end else begin
            chk(req_gnt == NR'(1 << w), "R3 grant", int'(req_gnt), 1 << w);
            e_vld = 1'b1;
            e_id  = w;
            e_op  = pop[w];
            e_idx = pidx[w];
            e_old = m_lock[e_idx];
            case (e_op)
                2'b01: begin e_ok = ~m_lock[e_idx]; m_lock[e_idx] = 1'b1; end
                2'b10: begin e_ok = 1'b1;           m_lock[e_idx] = 1'b0; end
                default: e_ok = 1'b1;
            endcase
            m_ptr = (w + 1) % NR;
            pv[w] = 1'b0;
        end
    endtask

    task automatic post(input int r, input logic [1:0] op, input int idx);
        pv[r] = 1'b1; pop[r] = op; pidx[r] = idx;
    endtask

    task automatic drain();
        bit busy = 1;
        while (busy) begin
            busy = 0;
            for (int r = 0; r < NR; r++) if (pv[r]) busy = 1;
            step();
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        for (int l = 0; l < NL; l++) begin m_lock[l] = 1'b0; obs_held[l] = 1'b0; end
        for (int r = 0; r < NR; r++) begin pv[r] = 1'b0; pop[r] = 2'b00; pidx[r] = 0; end
        m_ptr = 0; e_vld = 1'b0; e_ok = 1'b0; e_old = 1'b0; e_id = 0; e_idx = 0; e_op = 2'b00;
        tas_wins = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: no response straight after reset
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);

        // R1: every word reads free; all requesters read at once, requester 0 first
        for (int l = 0; l < NL; l += NR) begin
            for (int r = 0; r < NR; r++) post(r, 2'b00, l + r);
            drain();
        end

        // R9: every requester tries to take lock 2 in one cycle
        tas_wins = 0;
        for (int r = 0; r < NR; r++) post(r, 2'b01, 2);
        drain();
        step();
        chk(tas_wins == 1, "R9 single winner", tas_wins, 1);

        // R6: release held lock, then release it again while free
        post(1, 2'b10, 2); drain(); step();
        post(3, 2'b10, 2); drain(); step();
        chk(m_lock[2] == 1'b0, "R6 model free", int'(m_lock[2]), 0);
        // R7: code 11 reads without change, then R4 on freed word
        post(0, 2'b11, 2); drain();
        post(2, 2'b01, 2); drain();
        post(0, 2'b01, 2); drain();   // R5: fails on held word
        post(1, 2'b00, 2); drain();   // R5: word still held
        step();

        // random contention over a few locks
        for (int n = 0; n < 4000; n++) begin
            for (int r = 0; r < NR; r++) begin
                if (!pv[r] && ($urandom % 3) != 0) begin
                    int s = $urandom % 10;
                    logic [1:0] op = (s < 5) ? 2'b01 : (s < 8) ? 2'b10 : (s == 8) ? 2'b00 : 2'b11;
                    post(r, op, ($urandom % 3) + ((n > 2000) ? 4 : 0));
                end
            end
            step();
        end
        drain();
        step();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule